// File: doc/BRIEF.md
# I2C Line Front End with Spike Filter and Output Hold

This block sits between the raw serial clock and serial data pins and a slave protocol engine. It runs on a fast system clock. Each line goes through a two-flop synchronizer and then a spike filter. The filter changes its output only after the synchronized input has held a new level for a set number of clock cycles. From the filtered lines the block produces single-cycle event pulses:

- clock rising edge
- clock falling edge
- start condition
- repeated start condition
- stop condition

It also captures the data bit seen at each clock rising edge and keeps a flag that tracks whether a transfer is open.

On the way out, the engine asks for the data line to be pulled low with a request bit. The block passes that request to an open-drain pull enable. It holds the pull enable frozen for a minimum number of cycles after every filtered clock falling edge. This keeps the slave's own data changes clear of the clock edge, so another device never sees them as a start or stop condition. All widths are derived from the clock period and the nanosecond limits, which are parameters.

Top module: `i2c_line_frontend`

## Requirements
- R1: After reset the outputs `start_o`, `stop_o`, `rstart_o`, `scl_rise_o` and `scl_fall_o` are 0, `busy_o` is 0, `sda_pull_o` is 0 and `rx_bit_o` is 1 (both lines idle high).
- R2: A level change on either line that lasts 5 system cycles (50 ns at 10 ns period) or less produces no event. A change that lasts 6 cycles or more is accepted.
- R3: A high-to-low data transition while the clock is high gives a one-cycle `start_o` pulse. It appears 9 cycles after the pin change: 2 synchronizer, 6 filter, 1 output register.
- R4: A low-to-high data transition while the clock is high gives a one-cycle `stop_o` pulse. Start and stop never pulse in the same cycle.
- R5: Each accepted clock rising edge gives one `scl_rise_o` pulse and each falling edge one `scl_fall_o` pulse. Data changes while the clock is low give neither start nor stop.
- R6: `rx_bit_o` takes the filtered data level at each clock rising edge, in the same cycle as the `scl_rise_o` pulse, and holds it until the next rising edge.
- R7: `busy_o` goes to 1 with a start pulse and returns to 0 with a stop pulse.
- R8: A start while `busy_o` is 1 also pulses `rstart_o` in the same cycle. A start from the idle state does not.
- R9: `sda_pull_o` (1 = line pulled low) stays unchanged for at least 30 cycles (300 ns) after a `scl_fall_o` pulse. Outside that window it follows `sda_pull_req_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw serial clock pin level |
| sda_i | input | 1 | Raw serial data pin level |
| sda_pull_req_i | input | 1 | Engine request to pull the data line low |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| rstart_o | output | 1 | Start-while-busy pulse |
| scl_rise_o | output | 1 | Filtered clock rising edge pulse |
| scl_fall_o | output | 1 | Filtered clock falling edge pulse |
| rx_bit_o | output | 1 | Data level captured at the last clock rise |
| busy_o | output | 1 | Transfer open between start and stop |
| sda_pull_o | output | 1 | Open-drain pull-low enable for the data pin |

## Verification
Two functions can meet in one cycle:

- **Start and repeated start.** A start arriving while a transfer is open must raise `start_o` and `rstart_o` together. The stimulus table provokes this by issuing a start mid-transfer. It is judged by matching event-count deltas for both pulses against `busy_o`.
- **Falling-edge hold and pull request.** The engine's pull request is changed in the very cycle the `scl_fall_o` pulse appears. The output must still be unchanged 20 cycles later and must have taken the new value 40 cycles later.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned N_LINES  = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic rstart;
    logic rise;
    logic fall;
  } bus_evt_t;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/i2cfe_sync.sv
module i2cfe_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2cfe_spike_filter.sv
module i2cfe_spike_filter #(
  parameter int unsigned STABLE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int unsigned CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (line_i != lvl_q) begin
      if (cnt_q == CNT_LAST) begin
        lvl_d = line_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign line_o = lvl_q;

  AST_FILT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(line_i) == lvl_q)); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R2

endmodule

// File: rtl/i2cfe_cond_detect.sv
module i2cfe_cond_detect
  import i2cfe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_f_i,
  input  logic     sda_f_i,
  output bus_evt_t evt_o,
  output logic     busy_o,
  output logic     bit_o
);

  logic     scl_q, sda_q;
  logic     busy_q, busy_d;
  logic     bit_q, bit_d;
  bus_evt_t evt_q, evt_d;

  always_comb begin
    evt_d.rise   = scl_f_i & ~scl_q;
    evt_d.fall   = ~scl_f_i & scl_q;
    evt_d.start  = scl_q & scl_f_i & sda_q & ~sda_f_i;
    evt_d.stop   = scl_q & scl_f_i & ~sda_q & sda_f_i;
    evt_d.rstart = evt_d.start & busy_q;

    busy_d = busy_q;
    if (evt_d.start)     busy_d = 1'b1;
    else if (evt_d.stop) busy_d = 1'b0;

    bit_d = evt_d.rise ? sda_f_i : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
      bit_q  <= 1'b1;
      evt_q  <= '0;
    end else begin
      scl_q  <= scl_f_i;
      sda_q  <= sda_f_i;
      busy_q <= busy_d;
      bit_q  <= bit_d;
      evt_q  <= evt_d;
    end
  end

  assign evt_o  = evt_q;
  assign busy_o = busy_q;
  assign bit_o  = bit_q;

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_q.start && evt_q.stop)); // R4

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.start |=> !evt_q.start); // R3

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_q.rise && evt_q.fall)); // R5

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.start |-> busy_q); // R7

  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.stop |-> !busy_q); // R7

  AST_RSTART_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.rstart |-> (evt_q.start && $past(busy_q))); // R8

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q.rise |-> $stable(bit_q)); // R6

endmodule

// File: rtl/i2cfe_sda_hold.sv
module i2cfe_sda_hold #(
  parameter int unsigned HOLD_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall_i,
  input  logic pull_req_i,
  output logic pull_o
);

  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          pull_q, pull_d;
  logic          upd_en;

  assign upd_en = (hold_q == '0) && !scl_fall_i;

  always_comb begin
    hold_d = hold_q;
    if (scl_fall_i)        hold_d = HW'(HOLD_CYC);
    else if (hold_q != '0) hold_d = hold_q - 1'b1;

    pull_d = pull_q;
    if (upd_en) pull_d = pull_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pull_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pull_q <= pull_d;
    end
  end

  assign pull_o = pull_q;

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |=> $stable(pull_q)); // R9

  AST_FALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_i |=> $stable(pull_q)); // R9

endmodule

// File: rtl/i2c_line_frontend.sv
module i2c_line_frontend
  import i2cfe_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPIKE_NS      = 50,
  parameter int unsigned HOLD_NS       = 300,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sda_pull_req_i,
  output logic start_o,
  output logic stop_o,
  output logic rstart_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic rx_bit_o,
  output logic busy_o,
  output logic sda_pull_o
);

  localparam int unsigned FILT_CYC = SPIKE_NS / CLK_PERIOD_NS + 1;
  localparam int unsigned HOLD_CYC = ceil_div(HOLD_NS, CLK_PERIOD_NS);

  logic              rst_meta_q, rst_sync_q;
  logic              rst_core_n;
  logic [N_LINES-1:0] raw_lines, sync_lines, filt_lines;
  bus_evt_t          evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rst_core_n = rst_sync_q;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  i2cfe_sync #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (raw_lines),
    .q_o   (sync_lines)
  );

  for (genvar g = 0; g < int'(N_LINES); g++) begin : g_filt
    i2cfe_spike_filter #(
      .STABLE_CYC (FILT_CYC)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .line_i (sync_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  i2cfe_cond_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .scl_f_i (filt_lines[LINE_SCL]),
    .sda_f_i (filt_lines[LINE_SDA]),
    .evt_o   (evt),
    .busy_o  (busy_o),
    .bit_o   (rx_bit_o)
  );

  i2cfe_sda_hold #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .scl_fall_i (evt.fall),
    .pull_req_i (sda_pull_req_i),
    .pull_o     (sda_pull_o)
  );

  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign rstart_o   = evt.rstart;
  assign scl_rise_o = evt.rise;
  assign scl_fall_o = evt.fall;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (!busy_o && !sda_pull_o)); // R1

  AST_COND_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (start_o || stop_o) |-> $past(filt_lines[LINE_SCL])); // R5

endmodule

// File: tb/i2c_line_frontend_bench.sv
module i2c_line_frontend_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 14;
  localparam int N_VEC      = 17;

  // {scl, sda, d_start, d_stop, d_rise, d_fall, d_rstart, busy, rx_bit}
  localparam logic [8:0] VEC [N_VEC] = '{
    9'b11_00000_01,  // idle
    9'b10_10000_11,  // start
    9'b00_00010_11,  // scl fall
    9'b01_00000_11,  // sda moves while scl low
    9'b11_00100_11,  // rise, bit 1
    9'b01_00010_11,
    9'b00_00000_11,
    9'b10_00100_10,  // rise, bit 0
    9'b00_00010_10,
    9'b01_00000_10,
    9'b11_00100_11,  // rise, bit 1
    9'b10_10001_11,  // repeated start
    9'b00_00010_11,
    9'b10_00100_10,  // rise, bit 0
    9'b11_01000_00,  // stop
    9'b10_10000_10,  // fresh start
    9'b11_01000_00   // stop
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda, pull_req;
  logic start_o, stop_o, rstart_o, scl_rise_o, scl_fall_o, rx_bit_o, busy_o, sda_pull_o;

  int errors = 0;
  int checks = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0, n_rstart = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_line_frontend u_i2c_line_frontend (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl),
    .sda_i          (sda),
    .sda_pull_req_i (pull_req),
    .start_o        (start_o),
    .stop_o         (stop_o),
    .rstart_o       (rstart_o),
    .scl_rise_o     (scl_rise_o),
    .scl_fall_o     (scl_fall_o),
    .rx_bit_o       (rx_bit_o),
    .busy_o         (busy_o),
    .sda_pull_o     (sda_pull_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_o)    n_start++;
      if (stop_o)     n_stop++;
      if (scl_rise_o) n_rise++;
      if (scl_fall_o) n_fall++;
      if (rstart_o)   n_rstart++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int b_start, b_stop, b_rise, b_fall, b_rstart;
    int seen;
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; pull_req = 1'b0;
    cycles(4);
    // R1: reset state
    check("R1 start", start_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 pull", sda_pull_o, 0);
    check("R1 bit", rx_bit_o, 1);
    rst_n = 1'b1;
    cycles(SETTLE);
    check("R1 after release", {start_o, stop_o, rstart_o, scl_rise_o, scl_fall_o, busy_o}, 0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < N_VEC; i++) begin
      b_start = n_start; b_stop = n_stop; b_rise = n_rise; b_fall = n_fall; b_rstart = n_rstart;
      scl = VEC[i][8]; sda = VEC[i][7];
      cycles(SETTLE);
      check("R3 start count", n_start - b_start, int'(VEC[i][6]));
      check("R4 stop count", n_stop - b_stop, int'(VEC[i][5]));
      check("R5 rise count", n_rise - b_rise, int'(VEC[i][4]));
      check("R5 fall count", n_fall - b_fall, int'(VEC[i][3]));
      check("R8 rstart count", n_rstart - b_rstart, int'(VEC[i][2]));
      check("R7 busy", busy_o, int'(VEC[i][1]));
      check("R6 rx bit", rx_bit_o, int'(VEC[i][0]));
    end

    // R3: exact latency of the start pulse and its single-cycle width
    sda = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk); @(negedge clk);
      if (k >= 8) check("R3 latency", start_o, (k == 9) ? 1 : 0);
    end
    sda = 1'b1;
    cycles(SETTLE);
    check("R7 idle after stop", busy_o, 0);

    // R2: 5-cycle data spike rejected
    b_start = n_start; b_stop = n_stop;
    sda = 1'b0; cycles(5); sda = 1'b1;
    cycles(SETTLE + 6);
    check("R2 short sda spike start", n_start - b_start, 0);
    check("R2 short sda spike stop", n_stop - b_stop, 0);

    // R2: 6-cycle data pulse accepted
    sda = 1'b0; cycles(6); sda = 1'b1;
    cycles(SETTLE + 6);
    check("R2 long sda pulse start", n_start - b_start, 1);
    check("R2 long sda pulse stop", n_stop - b_stop, 1);

    // R2: 5-cycle clock glitch while low rejected
    scl = 1'b0; cycles(SETTLE);
    b_rise = n_rise;
    scl = 1'b1; cycles(5); scl = 1'b0;
    cycles(SETTLE + 6);
    check("R2 short scl spike", n_rise - b_rise, 0);

    // R9: pull request changes right at the falling-edge pulse
    scl = 1'b1; cycles(SETTLE + 40);
    scl = 1'b0;
    seen = 0;
    for (int k = 0; k < 40 && seen == 0; k++) begin
      @(negedge clk);
      if (scl_fall_o) seen = 1;
    end
    check("R9 fall seen", seen, 1);
    pull_req = 1'b1;
    cycles(20);
    check("R9 held after fall", sda_pull_o, 0);
    cycles(20);
    check("R9 follows after hold", sda_pull_o, 1);
    pull_req = 1'b0;
    cycles(2);
    check("R9 follows outside hold", sda_pull_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule